// File: doc/BRIEF.md
# Dithered PID Duty Calculator

Once per switching period a regulator loop delivers a small signed error code with a one-cycle strobe. This block turns that code into the duty word for a 7-bit pulse-width modulator. It evaluates a two's complement proportional-integral-derivative law, adds a feedforward word that encodes the reference voltage, and limits the result to the legal duty range. All values are normalised to the input voltage. The law is computed in eighths of a hardware duty step, so each result is 10 bits wide.

The upper 7 bits of the result go straight to the modulator. The lower 3 bits form a fraction. The block realises that fraction over time: across each run of eight periods, it raises the hardware word by one in as many periods as the fraction counts, and it spreads those raised periods evenly. Two level inputs override the calculation. One forces full duty and the other forces zero duty. An active override leaves the integrator untouched.

Top module: `duty_pid_dither`

## Requirements
- R1: A result appears on `duty_hw` together with a one-cycle `duty_vld` pulse exactly two clock cycles after the edge that samples `err_valid`. `duty_vld` is never high at any other time.
- R2: The unclamped result, in eighths of a hardware step, is u = ff + Kp·e + Kd·(e − e_prev) + I_new, where I_new = I + Ki·e. All terms are signed two's complement and the feedforward word is unsigned.
- R3: The integrator takes the value I_new only in periods where the result is neither clamped nor overridden. In every other period it keeps its value.
- R4: The result is limited to the range 0 to 1016 (127·8). A negative u gives 0 and a u above 1016 gives 1016.
- R5: The limited result q is split into a hardware word q>>3 and a fraction f = q mod 8. The output is the hardware word, plus one in the periods that the dither pattern selects.
- R6: A 3-bit period counter starts at 0 after reset and advances on every result. A period is raised by one when the bit-reversed counter value is less than f. As a result, any eight consecutive periods carry exactly f raised periods.
- R7: When `force_full` is high at the strobe, the output is 127, the integrator is held, and the gains and error have no effect on that result.
- R8: When `force_zero` is high at the strobe, the output is 0. This holds even if `force_full` is also high, and the integrator is held.
- R9: The previous-error register captures every sampled error, including samples taken while an override is active.
- R10: Synchronous active-high reset clears the integrator, the previous error, the period counter, `duty_hw` and `duty_vld`.
- R11: `duty_hw` keeps its value in every cycle in which `duty_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle strobe, once per switching period |
| err_code | input | ERR_W | Signed error code |
| ff_word | input | FF_W | Unsigned feedforward (reference) in eighths of a duty step |
| gain_p | input | GAIN_W | Signed proportional gain |
| gain_i | input | GAIN_W | Signed integral gain |
| gain_d | input | GAIN_W | Signed derivative gain |
| force_full | input | 1 | Override to full duty |
| force_zero | input | 1 | Override to zero duty, wins over force_full |
| duty_hw | output | HW_W | Hardware duty word for the modulator |
| duty_vld | output | 1 | Pulses when duty_hw takes a new value |

## Verification
Each result is due two cycles after the edge that samples its strobe. The first cycle registers the limited law and the integrator, and the second registers the dithered word. The driver raises `err_valid` for one cycle and queues the expected word from an independent model of R2 to R9. The monitor samples on the falling edge and compares against the queue only when `duty_vld` is high. In idle cycles the monitor checks that the word is held. Totals over eight consecutive periods are compared against 8·hw + f, which tests the fraction independently of where the pattern starts.

// File: rtl/duty_pkg.sv
package duty_pkg;
  typedef enum logic [2:0] {
    SEL_PASS,
    SEL_LOW,
    SEL_HIGH,
    SEL_OFF,
    SEL_ON
  } duty_sel_e;
endpackage

// File: rtl/duty_limit.sv
module duty_limit
  import duty_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int HW_W  = 7,
  parameter int FR_W  = 3,
  localparam int DUTY_W = HW_W + FR_W
) (
  input  logic signed [ACC_W-1:0] u_raw,
  input  logic                    frc_full,
  input  logic                    frc_zero,
  output logic [DUTY_W-1:0]       q,
  output logic                    commit
);
  localparam int DUTY_MAX = ((1 << HW_W) - 1) << FR_W;
  localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'(DUTY_MAX);

  duty_sel_e sel;

  always_comb begin
    if (frc_zero)              sel = SEL_OFF;
    else if (frc_full)         sel = SEL_ON;
    else if (u_raw[ACC_W-1])   sel = SEL_LOW;
    else if (u_raw > MAX_S)    sel = SEL_HIGH;
    else                       sel = SEL_PASS;
  end

  always_comb begin
    case (sel)
      SEL_PASS:          q = u_raw[DUTY_W-1:0];
      SEL_HIGH, SEL_ON:  q = DUTY_W'(DUTY_MAX);
      default:           q = '0;
    endcase
    commit = (sel == SEL_PASS);
  end
endmodule

// File: rtl/duty_pid_core.sv
module duty_pid_core #(
  parameter int ERR_W  = 5,
  parameter int GAIN_W = 8,
  parameter int FF_W   = 10,
  parameter int HW_W   = 7,
  parameter int FR_W   = 3,
  parameter int ACC_W  = 20,
  localparam int DUTY_W = HW_W + FR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic signed [ERR_W-1:0]  err,
  input  logic [FF_W-1:0]          ff,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  input  logic                     frc_full,
  input  logic                     frc_zero,
  output logic [DUTY_W-1:0]        q_out,
  output logic                     q_vld
);
  logic signed [ACC_W-1:0] integ_q;
  logic signed [ERR_W-1:0] eprev_q;

  logic signed [ACC_W-1:0] e_x, ep_x, kp_x, ki_x, kd_x, ff_x;
  logic signed [ACC_W-1:0] diff, p_term, i_term, d_term, i_new, u_raw;
  logic [DUTY_W-1:0]       q_nxt;
  logic                    commit;

  always_comb begin
    e_x  = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
    ep_x = {{(ACC_W-ERR_W){eprev_q[ERR_W-1]}}, eprev_q};
    kp_x = {{(ACC_W-GAIN_W){kp[GAIN_W-1]}}, kp};
    ki_x = {{(ACC_W-GAIN_W){ki[GAIN_W-1]}}, ki};
    kd_x = {{(ACC_W-GAIN_W){kd[GAIN_W-1]}}, kd};
    ff_x = {{(ACC_W-FF_W){1'b0}}, ff};
    diff   = e_x - ep_x;
    p_term = kp_x * e_x;
    i_term = ki_x * e_x;
    d_term = kd_x * diff;
    i_new  = integ_q + i_term;
    u_raw  = ff_x + p_term + d_term + i_new;
  end

  duty_limit #(
    .ACC_W(ACC_W),
    .HW_W (HW_W),
    .FR_W (FR_W)
  ) u_limit (
    .u_raw   (u_raw),
    .frc_full(frc_full),
    .frc_zero(frc_zero),
    .q       (q_nxt),
    .commit  (commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      eprev_q <= '0;
      q_out   <= '0;
      q_vld   <= 1'b0;
    end else begin
      q_vld <= smp_vld;
      if (smp_vld) begin
        eprev_q <= err;
        q_out   <= q_nxt;
        if (commit) integ_q <= i_new;
      end
    end
  end
endmodule

// File: rtl/duty_dither.sv
module duty_dither #(
  parameter int HW_W = 7,
  parameter int FR_W = 3,
  localparam int DUTY_W = HW_W + FR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DUTY_W-1:0] q_in,
  output logic [HW_W-1:0]   hw_out,
  output logic              out_vld
);
  logic [FR_W-1:0] phase_q;
  logic [FR_W-1:0] phase_rev;
  logic [HW_W-1:0] base;
  logic [FR_W-1:0] frac;
  logic            bump;

  for (genvar gi = 0; gi < FR_W; gi++) begin : g_rev
    assign phase_rev[gi] = phase_q[FR_W-1-gi];
  end

  always_comb begin
    base = q_in[DUTY_W-1:FR_W];
    frac = q_in[FR_W-1:0];
    bump = (phase_rev < frac);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      hw_out  <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        hw_out  <= base + {{(HW_W-1){1'b0}}, bump};
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/duty_pid_dither.sv
module duty_pid_dither #(
  parameter int ERR_W  = 5,
  parameter int GAIN_W = 8,
  parameter int FF_W   = 10,
  parameter int HW_W   = 7,
  parameter int FR_W   = 3,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic [ERR_W-1:0]  err_code,
  input  logic [FF_W-1:0]   ff_word,
  input  logic [GAIN_W-1:0] gain_p,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [GAIN_W-1:0] gain_d,
  input  logic              force_full,
  input  logic              force_zero,
  output logic [HW_W-1:0]   duty_hw,
  output logic              duty_vld
);
  localparam int DUTY_W = HW_W + FR_W;

  logic [DUTY_W-1:0] q_mid;
  logic              q_mid_vld;

  duty_pid_core #(
    .ERR_W (ERR_W),
    .GAIN_W(GAIN_W),
    .FF_W  (FF_W),
    .HW_W  (HW_W),
    .FR_W  (FR_W),
    .ACC_W (ACC_W)
  ) u_pid (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (err_valid),
    .err     ($signed(err_code)),
    .ff      (ff_word),
    .kp      ($signed(gain_p)),
    .ki      ($signed(gain_i)),
    .kd      ($signed(gain_d)),
    .frc_full(force_full),
    .frc_zero(force_zero),
    .q_out   (q_mid),
    .q_vld   (q_mid_vld)
  );

  duty_dither #(
    .HW_W(HW_W),
    .FR_W(FR_W)
  ) u_dither (
    .clk    (clk),
    .rst    (rst),
    .in_vld (q_mid_vld),
    .q_in   (q_mid),
    .hw_out (duty_hw),
    .out_vld(duty_vld)
  );
endmodule

// File: rtl/duty_pid_dither_chk.sv
module duty_pid_dither_chk #(
  parameter int HW_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            err_valid,
  input logic            force_full,
  input logic            force_zero,
  input logic [HW_W-1:0] duty_hw,
  input logic            duty_vld
);
  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    duty_vld |-> $past(err_valid, 2)); // R1

  AST_FORCE_FULL: assert property (@(posedge clk) disable iff (rst)
    (err_valid && force_full && !force_zero) |-> ##2 (duty_vld && duty_hw == {HW_W{1'b1}})); // R7

  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (err_valid && force_zero) |-> ##2 (duty_vld && duty_hw == '0)); // R8

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !duty_vld |-> $stable(duty_hw)); // R11
endmodule

bind duty_pid_dither duty_pid_dither_chk #(.HW_W(HW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .err_valid (err_valid),
  .force_full(force_full),
  .force_zero(force_zero),
  .duty_hw   (duty_hw),
  .duty_vld  (duty_vld)
);

// File: tb/duty_pid_dither_tb.sv
module duty_pid_dither_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 5, GAIN_W = 8, FF_W = 10, HW_W = 7, FR_W = 3;
  localparam int DMAX = 1016;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic [ERR_W-1:0] err_code = '0;
  logic [FF_W-1:0] ff_word = '0;
  logic [GAIN_W-1:0] gain_p = '0, gain_i = '0, gain_d = '0;
  logic force_full = 1'b0, force_zero = 1'b0;
  logic [HW_W-1:0] duty_hw;
  logic duty_vld;

  int checks = 0;
  int errors = 0;
  int m_integ = 0, m_eprev = 0, m_phase = 0;
  int exp_q[$];
  string tag_q[$];
  int acc_sum = 0;
  int last_out = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_pid_dither u_dut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_code(err_code),
    .ff_word(ff_word), .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d),
    .force_full(force_full), .force_zero(force_zero),
    .duty_hw(duty_hw), .duty_vld(duty_vld)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rev3(int p);
    return ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1);
  endfunction

  task automatic send(string tag, int e, int ff, int kp, int ki, int kd, bit fon, bit foff);
    int inew, u, q, hw, f, o;
    inew = m_integ + ki * e;
    u = ff + kp * e + kd * (e - m_eprev) + inew;
    if (foff) q = 0;
    else if (fon) q = DMAX;
    else if (u < 0) q = 0;
    else if (u > DMAX) q = DMAX;
    else begin
      q = u;
      m_integ = inew;
    end
    m_eprev = e;
    hw = q >> 3;
    f = q & 7;
    o = hw + ((rev3(m_phase) < f) ? 1 : 0);
    m_phase = (m_phase + 1) % 8;
    exp_q.push_back(o);
    tag_q.push_back(tag);
    @(negedge clk);
    err_code = ERR_W'(e);
    ff_word = FF_W'(ff);
    gain_p = GAIN_W'(kp);
    gain_i = GAIN_W'(ki);
    gain_d = GAIN_W'(kd);
    force_full = fon;
    force_zero = foff;
    err_valid = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each result; idle cycles must hold (R11)
  always @(negedge clk) begin
    if (!rst) begin
      if (duty_vld) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected result", 1, 0);
        end else begin
          check(tag_q.pop_front(), int'(duty_hw), exp_q.pop_front());
        end
        acc_sum += int'(duty_hw);
        last_out = int'(duty_hw);
      end else begin
        check("R11 hold", int'(duty_hw), last_out);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset duty", int'(duty_hw), 0);
    check("R10 reset vld", int'(duty_vld), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2: feedforward alone
    send("R2 ff only", 0, 400, 0, 0, 0, 0, 0);
    send("R1 ff only", 0, 400, 0, 0, 0, 0, 0);

    // R5 R6: fraction 3 over eight periods
    acc_sum = 0;
    for (int i = 0; i < 8; i++) send("R6 frac3", 0, 403, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    check("R6 eight-period total", acc_sum, 8 * 50 + 3);

    // R5 R6: fraction 4 over eight periods
    acc_sum = 0;
    for (int i = 0; i < 8; i++) send("R5 frac4", 0, 644, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    check("R5 eight-period total", acc_sum, 8 * 80 + 4);

    // R2: proportional and derivative terms
    send("R2 pd", 5, 500, 3, 0, 2, 0, 0);
    send("R2 pd", -4, 500, 3, 0, 2, 0, 0);
    send("R2 pd", 7, 500, 3, 0, 2, 0, 0);
    send("R2 pd", 0, 500, 3, 0, 2, 0, 0);

    // R3: integrator accumulation
    for (int i = 0; i < 4; i++) send("R3 integrate", 3, 300, 0, 2, 0, 0, 0);

    // R4: clamp high, then the integrator must be unchanged (R3)
    send("R4 clamp high", 15, 1000, 10, 2, 0, 0, 0);
    send("R3 frozen after high clamp", 0, 300, 0, 2, 0, 0, 0);
    // R4: clamp low
    send("R4 clamp low", -16, 0, 10, 2, 0, 0, 0);
    send("R3 frozen after low clamp", 0, 300, 0, 2, 0, 0, 0);

    // R7 R8 overrides, integrator held
    send("R7 force full", 5, 100, 1, 2, 0, 1, 0);
    send("R7 force full", -9, 0, 1, 2, 0, 1, 0);
    send("R8 force zero", 5, 900, 1, 2, 0, 0, 1);
    send("R8 zero wins", 5, 900, 1, 2, 0, 1, 1);
    send("R7 integ held", 0, 300, 0, 2, 0, 0, 0);

    // R9: forced sample still updates previous error
    send("R9 forced sample", 6, 300, 0, 0, 4, 1, 0);
    send("R9 derivative after force", 6, 300, 0, 0, 4, 0, 0);
    send("R9 derivative step", -2, 300, 0, 0, 4, 0, 0);

    repeat (6) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule